// File: doc/BRIEF.md
# Bufferless Notification Merge Node

One node of a bufferless mesh that tells every node which cores have ordered requests waiting to be sequenced. Each announcement is a vector with one bit per core plus a stop bit. The nodes never hold traffic back. When vectors meet at a node, the node combines them with a bitwise OR and sends the result to all of its neighbours in the next cycle. Because nothing waits, the worst-case spread time across the mesh is fixed.

Time is divided into windows of fixed length, and every node counts the same windows from a common synchronous reset. In the first cycle of a window the node starts fresh: it sends out only its own contribution, which is its core bit when it has pending notifications and the stop bit when its local queue is full. During the rest of the window it keeps OR-ing what it receives into what it already holds. In the last cycle it hands the merged vector to the local interface, unless the merged stop bit is set. In that case the whole window is discarded and any node whose bit was in it sends again in a later window.

A small counter records notifications that are owed to the mesh. While that counter is at its limit, new ordered requests are refused.

Top module: `notif_merge_node`

## Requirements
- R1: The window counter starts at the first cycle after reset and repeats every WINDOW_LEN cycles. `mergedValid` is high for exactly one cycle, only in the first cycle of a window, and only after at least one full window has completed.
- R2: Each cycle, every outgoing port carries the same value. Within a window the outgoing value never loses a bit: it is the OR of the previous outgoing value and all incoming vectors.
- R3: When the pending count is non-zero in the first cycle of a window, the node sets bit LOCAL_ID in the outgoing vector. It never adds that bit in any other cycle.
- R4: In the first cycle of a window the node ignores `linkIn` and the previous window's contents. The next outgoing value contains only the node's own contribution.
- R5: At the end of a window whose merged stop bit is clear, `mergedVec` takes the merged core bits (bits NUM_CORES-1:0) and `mergedValid` pulses. `mergedVec` keeps that value until the next clean window ends.
- R6: The pending count rises by one for each cycle in which `reqValid` and `reqAccept` are both high. `reqAccept` is low exactly when the count equals PEND_MAX.
- R7: If the merged stop bit (bit NUM_CORES) is set at the end of a window, no delivery happens and a notification sent in that window stays pending.
- R8: If `queueFull` is high in the first cycle of a window, the node sets the stop bit (bit NUM_CORES) in its outgoing vector.
- R9: The pending count drops by one at the end of each window that carried the local bit and finished with the stop bit clear.
- R10: During reset, all outgoing ports are zero, `mergedValid` is low and `reqAccept` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low, shared by all nodes |
| linkIn | input | NUM_PORTS*(NUM_CORES+1) | Vectors from the neighbours; each slice is {stop, core bits} |
| linkOut | output | NUM_PORTS*(NUM_CORES+1) | Latched merged vector, one copy per neighbour |
| reqValid | input | 1 | Local interface offers a new ordered request |
| reqAccept | output | 1 | The request may enter the main network (pending count below PEND_MAX) |
| queueFull | input | 1 | Local notification queue is full; raises the stop bit |
| mergedValid | output | 1 | One-cycle pulse marking delivery of a clean window |
| mergedVec | output | NUM_CORES | Merged core bits of the last clean window |

## Verification
Uncorrelated sparse random vectors on each port, arriving throughout the window, show whether the merge really accumulates and whether the start-of-window clear drops leftovers from the previous window. A long stretch of back-to-back requests drives the pending counter to saturation and separates a correct acceptance limit from an off-by-one limit. Windows with `queueFull` held, and windows with a stop bit arriving from a neighbour in the middle of the window, show whether discarded windows are kept apart from clean ones. They also show that the owed notification is retained rather than consumed by a dropped window.

// File: rtl/notif_pkg.sv
package notif_pkg;
  // strobes from the control half to the datapath half
  typedef struct packed {
    logic winStart;  // first cycle of a window
    logic winEnd;    // last cycle of a window
    logic inject;    // local core bit goes out this window
    logic stopReq;   // local stop request goes out this window
  } ctrlStrobe_t;
endpackage

// File: rtl/notif_ctrl.sv
module notif_ctrl
  import notif_pkg::*;
#(
  parameter int WINDOW_LEN = 13,
  parameter int PEND_MAX   = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        queueFull,
  input  logic        endStop,
  output ctrlStrobe_t strobe,
  output logic        reqAccept
);
  localparam int CW = (WINDOW_LEN > 2) ? $clog2(WINDOW_LEN) : 1;
  localparam int PW = $clog2(PEND_MAX + 1);
  localparam logic [CW-1:0] LAST_SLOT = CW'(WINDOW_LEN - 1);
  localparam logic [PW-1:0] PEND_TOP  = PW'(PEND_MAX);

  logic [CW-1:0] winCnt;
  logic [PW-1:0] pendCnt;
  logic          sentFlag;
  logic          incPend;
  logic          decPend;

  always_comb begin
    strobe.winStart = (winCnt == '0);
    strobe.winEnd   = (winCnt == LAST_SLOT);
    strobe.inject   = strobe.winStart && (pendCnt != '0);
    strobe.stopReq  = strobe.winStart && queueFull;
  end

  assign reqAccept = (pendCnt < PEND_TOP);
  assign incPend   = reqValid && reqAccept;
  assign decPend   = strobe.winEnd && sentFlag && !endStop;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winCnt   <= '0;
      pendCnt  <= '0;
      sentFlag <= 1'b0;
    end else begin
      winCnt <= strobe.winEnd ? '0 : winCnt + 1'b1;
      if (strobe.winStart) sentFlag <= strobe.inject;
      pendCnt <= pendCnt + PW'(incPend) - PW'(decPend);
    end
  end
endmodule

// File: rtl/notif_datapath.sv
module notif_datapath
  import notif_pkg::*;
#(
  parameter int NUM_CORES = 16,
  parameter int NUM_PORTS = 4,
  parameter int LOCAL_ID  = 5
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  ctrlStrobe_t                         strobe,
  input  logic [NUM_PORTS*(NUM_CORES+1)-1:0]  linkIn,
  output logic [NUM_PORTS*(NUM_CORES+1)-1:0]  linkOut,
  output logic                                mergedValid,
  output logic [NUM_CORES-1:0]                mergedVec,
  output logic                                endStop
);
  localparam int VEC_W    = NUM_CORES + 1;
  localparam int STOP_IDX = NUM_CORES;

  logic [VEC_W-1:0] portOr [NUM_PORTS+1];
  logic [VEC_W-1:0] localVec;
  logic [VEC_W-1:0] accVec;
  logic [VEC_W-1:0] mergedNow;

  assign portOr[0] = '0;
  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_or
    assign portOr[g+1] = portOr[g] | linkIn[g*VEC_W +: VEC_W];
  end

  always_comb begin
    localVec           = '0;
    localVec[LOCAL_ID] = strobe.inject;
    localVec[STOP_IDX] = strobe.stopReq;
  end

  // window start drops everything held or arriving: fresh window
  assign mergedNow = strobe.winStart ? localVec : (accVec | portOr[NUM_PORTS]);
  assign endStop   = mergedNow[STOP_IDX];

  always_ff @(posedge clk) begin
    if (!rstN) accVec <= '0;
    else       accVec <= mergedNow;
  end

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_latch
    logic [VEC_W-1:0] portLatch;
    always_ff @(posedge clk) begin
      if (!rstN) portLatch <= '0;
      else       portLatch <= mergedNow;
    end
    assign linkOut[g*VEC_W +: VEC_W] = portLatch;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mergedValid <= 1'b0;
      mergedVec   <= '0;
    end else begin
      mergedValid <= strobe.winEnd && !mergedNow[STOP_IDX];
      if (strobe.winEnd && !mergedNow[STOP_IDX])
        mergedVec <= mergedNow[NUM_CORES-1:0];
    end
  end
endmodule

// File: rtl/notif_merge_node.sv
module notif_merge_node
  import notif_pkg::*;
#(
  parameter int NUM_CORES  = 16,
  parameter int NUM_PORTS  = 4,
  parameter int WINDOW_LEN = 13,
  parameter int PEND_MAX   = 4,
  parameter int LOCAL_ID   = 5
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [NUM_PORTS*(NUM_CORES+1)-1:0]  linkIn,
  output logic [NUM_PORTS*(NUM_CORES+1)-1:0]  linkOut,
  input  logic                                reqValid,
  output logic                                reqAccept,
  input  logic                                queueFull,
  output logic                                mergedValid,
  output logic [NUM_CORES-1:0]                mergedVec
);
  ctrlStrobe_t strobe;
  logic        endStop;

  notif_ctrl #(.WINDOW_LEN(WINDOW_LEN), .PEND_MAX(PEND_MAX)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .queueFull(queueFull),
    .endStop(endStop), .strobe(strobe), .reqAccept(reqAccept)
  );

  notif_datapath #(.NUM_CORES(NUM_CORES), .NUM_PORTS(NUM_PORTS), .LOCAL_ID(LOCAL_ID)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .linkIn(linkIn), .linkOut(linkOut),
    .mergedValid(mergedValid), .mergedVec(mergedVec), .endStop(endStop)
  );
endmodule

// File: rtl/notif_merge_node_chk.sv
module notif_merge_node_chk #(
  parameter int NUM_CORES  = 16,
  parameter int NUM_PORTS  = 4,
  parameter int WINDOW_LEN = 13,
  parameter int LOCAL_ID   = 5
) (
  input logic                               clk,
  input logic                               rstN,
  input logic [NUM_PORTS*(NUM_CORES+1)-1:0] linkOut,
  input logic                               mergedValid,
  input logic [NUM_CORES-1:0]               mergedVec,
  input logic                               queueFull
);
  localparam int VEC_W = NUM_CORES + 1;
  localparam int CW    = (WINDOW_LEN > 2) ? $clog2(WINDOW_LEN) : 1;
  localparam logic [NUM_CORES-1:0] OTHER_MASK = ~(NUM_CORES'(1) << LOCAL_ID);

  logic [CW-1:0]    chkCnt;
  logic             winSeen;
  logic             pastOk;
  logic [VEC_W-1:0] out0;

  assign out0 = linkOut[VEC_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chkCnt  <= '0;
      winSeen <= 1'b0;
      pastOk  <= 1'b0;
    end else begin
      pastOk <= 1'b1;
      if (chkCnt == CW'(WINDOW_LEN - 1)) begin
        chkCnt  <= '0;
        winSeen <= 1'b1;
      end else begin
        chkCnt <= chkCnt + 1'b1;
      end
    end
  end

  for (genvar g = 1; g < NUM_PORTS; g++) begin : g_same
    AST_PORTS_MATCH: assert property (@(posedge clk) disable iff (!rstN)
      linkOut[g*VEC_W +: VEC_W] == out0); // R2
  end

  AST_VALID_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    mergedValid |-> (chkCnt == '0 && winSeen)); // R1

  AST_GROW_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && chkCnt != CW'(1)) |-> (($past(out0) & ~out0) == '0)); // R2

  AST_FRESH_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (chkCnt == CW'(1)) |-> ((out0[NUM_CORES-1:0] & OTHER_MASK) == '0)); // R4

  AST_CLEAN_DELIVERY: assert property (@(posedge clk) disable iff (!rstN)
    (chkCnt == '0 && winSeen && !out0[NUM_CORES]) |-> (mergedValid && mergedVec == out0[NUM_CORES-1:0])); // R5

  AST_STOP_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (chkCnt == '0 && winSeen && out0[NUM_CORES]) |-> !mergedValid); // R7

  AST_STOP_RAISE: assert property (@(posedge clk) disable iff (!rstN)
    (chkCnt == '0 && queueFull) |=> out0[NUM_CORES]); // R8
endmodule

bind notif_merge_node notif_merge_node_chk #(
  .NUM_CORES(NUM_CORES), .NUM_PORTS(NUM_PORTS), .WINDOW_LEN(WINDOW_LEN), .LOCAL_ID(LOCAL_ID)
) u_chk (
  .clk(clk), .rstN(rstN), .linkOut(linkOut), .mergedValid(mergedValid),
  .mergedVec(mergedVec), .queueFull(queueFull)
);

// File: tb/sim_notif_merge_node.sv
module sim_notif_merge_node;
  localparam int N    = 16;
  localparam int P    = 4;
  localparam int W    = 13;
  localparam int PMAX = 4;
  localparam int LID  = 5;
  localparam int VW   = N + 1;

  logic          clk = 1'b0;
  logic          rstN;
  logic [P*VW-1:0] linkIn;
  logic [P*VW-1:0] linkOut;
  logic          reqValid, reqAccept, queueFull, mergedValid;
  logic [N-1:0]  mergedVec;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  notif_merge_node #(.NUM_CORES(N), .NUM_PORTS(P), .WINDOW_LEN(W), .PEND_MAX(PMAX), .LOCAL_ID(LID)) u0 (
    .clk(clk), .rstN(rstN), .linkIn(linkIn), .linkOut(linkOut), .reqValid(reqValid),
    .reqAccept(reqAccept), .queueFull(queueFull), .mergedValid(mergedValid), .mergedVec(mergedVec)
  );

  // reference model, written from the requirements
  int          mCnt, mPend;
  bit          mSent, mValid, mWasStart, mDec;
  logic [VW-1:0] mAcc, mOut, mIn, mInj;
  logic [N-1:0]  mVec;

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mPend = 0; mSent = 0; mValid = 0; mWasStart = 0; mDec = 0;
      mAcc = '0; mOut = '0; mVec = '0;
    end else begin
      bit st, fin, acc;
      st  = (mCnt == 0);
      fin = (mCnt == W - 1);
      mInj = '0;
      if (st && mPend != 0) mInj[LID] = 1'b1;  // R3
      if (st && queueFull)  mInj[N]   = 1'b1;  // R8
      mIn = '0;
      for (int p = 0; p < P; p++) mIn = mIn | linkIn[p*VW +: VW];
      mOut = st ? mInj : (mAcc | mIn);
      acc  = (mPend < PMAX);
      mDec = fin && mSent && !mOut[N];
      if (st) mSent = (mPend != 0);
      mPend = mPend + ((reqValid && acc) ? 1 : 0) - (mDec ? 1 : 0);
      mAcc = mOut;
      mValid = fin && !mOut[N];
      if (mValid) mVec = mOut[N-1:0];
      mWasStart = st;
      mCnt = fin ? 0 : mCnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compareAll();
    string tag;
    for (int p = 0; p < P; p++) begin
      if (mWasStart) tag = mOut[N] ? "R8" : (mOut[LID] ? "R3" : "R4");
      else           tag = "R2";
      chk(tag, 64'(linkOut[p*VW +: VW]), 64'(mOut));
    end
    chk(mOut[N] && mWasStart == 0 && mCnt == 0 ? "R7" : "R1", 64'(mergedValid), 64'(mValid));
    chk("R5", 64'(mergedVec), 64'(mVec));
    chk(mDec ? "R9" : "R6", 64'(reqAccept), 64'(mPend < PMAX));
  endtask

  task automatic driveRandom(input int qPct, input int rPct);
    for (int p = 0; p < P; p++) begin
      logic [N-1:0] bits;
      bits = N'($urandom & $urandom & $urandom);
      linkIn[p*VW +: VW] = {($urandom_range(99) < 2), bits};
    end
    reqValid  = ($urandom_range(99) < rPct);
    queueFull = ($urandom_range(99) < qPct);
  endtask

  initial begin
    void'($urandom(32'd7331));
    rstN = 0; linkIn = '0; reqValid = 0; queueFull = 0;
    repeat (3) @(negedge clk);
    for (int p = 0; p < P; p++) chk("R10", 64'(linkOut[p*VW +: VW]), 64'd0);
    chk("R10", 64'(mergedValid), 64'd0);
    chk("R10", 64'(reqAccept), 64'd1);
    rstN = 1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      compareAll();
      if (i < 60) begin              // saturate pending, quiet links
        linkIn = '0; reqValid = 1; queueFull = 0;
      end else if (i < 140) begin    // stop windows with traffic
        driveRandom(100, 0);
      end else if (i < 200) begin    // drain, no stop
        driveRandom(0, 0);
      end else begin
        driveRandom(8, 25);
      end
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule